// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the integer registers of a sixteen-register, 32-bit load-store core and resolves which physical copy an architectural index refers to. The choice depends on the index and on the mode field, bits [4:0] of the current status word. The current status word is kept inside the block. The data store has two combinational read ports and one write port, which stores on the rising clock edge. A separate port reaches the saved status word that belongs to the mode in force.

The fast-interrupt mode has private copies of indices 8 to 12. Each of the five exception modes has its own stack pointer (index 13), link register (index 14) and saved status word. User and System modes share the base copies and have no saved status word. Together with the current status word, the block holds 37 physical words.

A privileged handler raises `user_bank` to reach the user-mode copies of the data registers. An unknown mode encoding falls back to the user bank and raises a sticky error. All ports are plain control and data pins. There is no valid/ready stream, because every access completes in a fixed cycle and needs no back-pressure.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset, `cpsr_q` is 0x000000D3: mode Supervisor, bit 5 clear, bits 6 and 7 set. Every data register and every saved status word reads zero, and `mode_err` is low.
- R2: Indices 0 to 7 and 15 reach the same physical register in every mode.
- R3: In FIQ mode, indices 8 to 12 reach a private set of copies. Every other mode reaches the user copies.
- R4: Indices 13 and 14 have a separate copy in each of FIQ, IRQ, Supervisor, Abort and Undefined mode. User and System modes share one copy.
- R5: Each of the five exception modes keeps its own saved status word. Writing through `spsr_we` changes only the word of the current mode, and `spsr_rdata` shows that word.
- R6: In User or System mode, or in an unknown mode, `spsr_rdata` reads zero and a saved-status write changes no stored word. `spsr_invalid` is high exactly while `spsr_re` or `spsr_we` is high in such a mode.
- R7: A read of the register being written in the same cycle returns the old value on both ports. The new value appears from the next cycle on.
- R8: While `user_bank` is high, data-register reads and writes resolve as in User mode, whatever the current mode. The saved-status port still follows the real mode.
- R9: A mode field that is not one of the seven encodings maps the data registers to the user bank. `mode_err` rises on the clock edge after the status word holds such a field and stays high until reset.
- R10: `cpsr_we` loads `cpsr_wdata` into `cpsr_q` on the clock edge. The mode encodings are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpsr_we | input | 1 | Load the current status word |
| cpsr_wdata | input | 32 | New current status word |
| cpsr_q | output | 32 | Current status word; bits [4:0] select the mode |
| user_bank | input | 1 | Resolve data-register banking as User mode |
| ra_idx | input | 4 | Read port A architectural index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B architectural index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| spsr_re | input | 1 | Saved-status read access |
| spsr_we | input | 1 | Saved-status write |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved status word of the current mode |
| spsr_invalid | output | 1 | Saved-status access in a mode without one |
| mode_err | output | 1 | Sticky unknown-mode error |

## Verification
The assertions check on every cycle that indices 0 to 7 and 15 pass through unbanked and that an override forces the user mapping. They also check that a written value is visible on any read port that addresses it on the next cycle, that ignored saved-status writes leave all five words still, and that the mode error never clears. The bench sweeps every index through every mode, including one unknown encoding, and compares all reads with an arithmetic ownership model. Only these scenarios show that one mode's writes stay invisible to the other modes, that same-cycle reads return the old value, and that saved-status words stay separate per mode.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
  localparam int IDX_W      = 4;
  localparam int MODE_W     = 5;
  localparam int ARCH_REGS  = 1 << IDX_W;
  localparam int N_EXC      = 5;
  localparam int FIQ_LO     = 8;
  localparam int FIQ_HI     = 12;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;
  localparam int N_FIQ_PRIV = FIQ_HI - FIQ_LO + 1;
  localparam int FIQ_BASE   = ARCH_REGS;
  localparam int EXC_BASE   = FIQ_BASE + N_FIQ_PRIV;
  localparam int PHYS_DATA  = EXC_BASE + 2 * N_EXC;
  localparam int PHYS_W     = $clog2(PHYS_DATA);
  localparam int SLOT_W     = $clog2(N_EXC);

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  typedef struct packed {
    logic              known;
    logic              exc;
    logic [SLOT_W-1:0] slot;
  } mode_info_t;

  // Slot order: fast interrupt 0, interrupt 1, supervisor 2, abort 3, undefined 4
  function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
    mode_info_t r;
    r = '{known: 1'b1, exc: 1'b1, slot: '0};
    case (m)
      M_USR, M_SYS: r.exc = 1'b0;
      M_FIQ: r.slot = SLOT_W'(0);
      M_IRQ: r.slot = SLOT_W'(1);
      M_SVC: r.slot = SLOT_W'(2);
      M_ABT: r.slot = SLOT_W'(3);
      M_UND: r.slot = SLOT_W'(4);
      default: begin
        r.known = 1'b0;
        r.exc   = 1'b0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import mbrf_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [MODE_W-1:0] mode,
  input  logic              user_bank,
  output logic [PHYS_W-1:0] phys,
  output logic              mode_ok
);
  mode_info_t info;
  logic       use_exc;
  int         i_idx;
  int         i_phys;

  always_comb begin
    info    = decode_mode(mode);
    mode_ok = info.known;
    use_exc = info.exc && !user_bank;
    i_idx   = int'(idx);
    i_phys  = i_idx;
    if (use_exc) begin
      if (info.slot == '0 && i_idx >= FIQ_LO && i_idx <= FIQ_HI)
        i_phys = FIQ_BASE + (i_idx - FIQ_LO);
      else if (i_idx == SP_IDX || i_idx == LR_IDX)
        i_phys = EXC_BASE + 2 * int'(info.slot) + (i_idx - SP_IDX);
    end
    phys = PHYS_W'(i_phys);
  end

  always_comb begin
    if (!$isunknown({idx, mode, user_bank})) begin
      p_shared_r2: assert ((idx >= IDX_W'(FIQ_LO) && idx != IDX_W'(PC_IDX)) || phys == PHYS_W'(idx))
        else $error("unbanked index remapped");
      p_override_r8: assert (!user_bank || phys == PHYS_W'(idx))
        else $error("override did not select user bank");
      p_bad_mode_r9: assert (mode_ok || phys == PHYS_W'(idx))
        else $error("unknown mode left user bank");
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PHYS_W-1:0] wphys,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raphys,
  output logic [DATA_W-1:0] radata,
  input  logic [PHYS_W-1:0] rbphys,
  output logic [DATA_W-1:0] rbdata
);
  logic [DATA_W-1:0] mem [PHYS_DATA];

  for (genvar g = 0; g < PHYS_DATA; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem[g] <= '0;
      else if (we && wphys == PHYS_W'(g))       mem[g] <= wdata;
    end
  end

  assign radata = (int'(raphys) < PHYS_DATA) ? mem[raphys] : '0;
  assign rbdata = (int'(rbphys) < PHYS_DATA) ? mem[rbphys] : '0;

  p_write_seen_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (raphys != $past(wphys) || radata == $past(wdata)))
    else $error("port A missed last write");
  p_write_seen_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rbphys != $past(wphys) || rbdata == $past(wdata)))
    else $error("port B missed last write");
endmodule

// File: rtl/rf_spsr_bank.sv
module rf_spsr_bank
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              re,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              invalid
);
  logic [N_EXC-1:0][DATA_W-1:0] saved;
  mode_info_t info;
  logic       has_bank;

  always_comb begin
    info     = decode_mode(mode);
    has_bank = info.exc && (int'(info.slot) < N_EXC);
  end

  assign invalid = (re || we) && !has_bank;
  assign rdata   = has_bank ? saved[info.slot] : '0;

  for (genvar g = 0; g < N_EXC; g++) begin : g_saved
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        saved[g] <= '0;
      else if (we && has_bank && info.slot == SLOT_W'(g)) saved[g] <= wdata;
    end
  end

  p_ignored_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && invalid) |=> $stable(saved))
    else $error("saved status changed on invalid write");
  p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> rdata == '0)
    else $error("invalid access read nonzero");
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  input  logic              user_bank,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              spsr_re,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_rdata,
  output logic              spsr_invalid,
  output logic              mode_err
);
  localparam int N_PORTS = 3;
  localparam logic [DATA_W-1:0] CPSR_RST = DATA_W'({2'b11, 1'b0, M_SVC});

  logic [MODE_W-1:0]             cur_mode;
  logic [N_PORTS-1:0][IDX_W-1:0] port_idx;
  logic [N_PORTS-1:0][PHYS_W-1:0] port_phys;
  logic [N_PORTS-1:0]            port_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpsr_q <= CPSR_RST;
    else if (cpsr_we) cpsr_q <= cpsr_wdata;
  end

  assign cur_mode = cpsr_q[MODE_W-1:0];
  assign port_idx = {wr_idx, rb_idx, ra_idx};

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    rf_bank_map u_map (
      .idx      (port_idx[p]),
      .mode     (cur_mode),
      .user_bank(user_bank),
      .phys     (port_phys[p]),
      .mode_ok  (port_ok[p])
    );
  end

  rf_storage #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wphys (port_phys[2]),
    .wdata (wr_data),
    .raphys(port_phys[0]),
    .radata(ra_data),
    .rbphys(port_phys[1]),
    .rbdata(rb_data)
  );

  rf_spsr_bank #(.DATA_W(DATA_W)) u_spsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cur_mode),
    .re     (spsr_re),
    .we     (spsr_we),
    .wdata  (spsr_wdata),
    .rdata  (spsr_rdata),
    .invalid(spsr_invalid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_err <= 1'b0;
    else if (!(&port_ok)) mode_err <= 1'b1;
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err)
    else $error("mode error cleared");
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_err) |-> !$past(&port_ok))
    else $error("mode error without unknown mode");
  p_cpsr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |=> cpsr_q == $past(cpsr_wdata))
    else $error("status word not loaded");
endmodule

// File: tb/tb_mode_bank_regfile.sv
module tb_mode_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpsr_we = 1'b0;
  logic [31:0] cpsr_wdata = '0;
  logic [31:0] cpsr_q;
  logic        user_bank = 1'b0;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [31:0] ra_data, rb_data;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        spsr_re = 1'b0, spsr_we = 1'b0;
  logic [31:0] spsr_wdata = '0;
  logic [31:0] spsr_rdata;
  logic        spsr_invalid, mode_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [8][16];
  logic [4:0]  modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00101};

  always #5 clk = ~clk;

  mode_bank_regfile dut (
    .clk(clk), .rst_n(rst_n), .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
    .cpsr_q(cpsr_q), .user_bank(user_bank), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .spsr_re(spsr_re), .spsr_we(spsr_we),
    .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
    .spsr_invalid(spsr_invalid), .mode_err(mode_err)
  );

  // Owner bank: 0 user, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
  function automatic int owner(input logic [4:0] m, input int idx, input logic ovr);
    if (ovr || idx < 8 || idx == 15) return 0;
    if (idx <= 12) return (m == 5'b10001) ? 1 : 0;
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic string req_of(input int idx, input logic [4:0] m);
    if (m == 5'b00101) return "R9";
    if (idx < 8 || idx == 15) return "R2";
    if (idx <= 12) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    cpsr_we = 1'b1;
    cpsr_wdata = {24'h0, 2'b11, 1'b0, m};
    @(negedge clk);
    cpsr_we = 1'b0;
  endtask

  task automatic do_write(input int idx, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = 4'(idx);
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_pair(input int ia, input int ib, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    ra_idx = 4'(ia);
    rb_idx = 4'(ib);
    #1;
    a = ra_data;
    b = rb_data;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 16; i++) model[k][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", cpsr_q, 32'h0000_00D3);
    chk("R1", {31'h0, mode_err}, 32'h0);
    chk("R1", spsr_rdata, 32'h0);
    for (int i = 0; i < 16; i++) begin
      read_pair(i, 15 - i, a, b);
      chk("R1", a, 32'h0);
      chk("R1", b, 32'h0);
    end

    // Write sweep across all modes, including one unknown encoding
    for (int mi = 0; mi < 8; mi++) begin
      if (mi == 7) begin
        #1 chk("R9", {31'h0, mode_err}, 32'h0);
      end
      set_mode(modes[mi]);
      #1 chk("R10", cpsr_q, {24'h0, 2'b11, 1'b0, modes[mi]});
      for (int i = 0; i < 16; i++) begin
        logic [31:0] v;
        v = 32'h1000_0000 * (mi + 1) + 32'h100 * i + 32'h5A;
        do_write(i, v);
        model[owner(modes[mi], i, 1'b0)][i] = v;
      end
    end
    #1 chk("R9", {31'h0, mode_err}, 32'h1);

    // Read sweep across all modes
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(modes[mi]);
      for (int i = 0; i < 16; i++) begin
        read_pair(i, 15 - i, a, b);
        chk(req_of(i, modes[mi]), a, model[owner(modes[mi], i, 1'b0)][i]);
        chk(req_of(15 - i, modes[mi]), b, model[owner(modes[mi], 15 - i, 1'b0)][15 - i]);
      end
    end
    #1 chk("R9", {31'h0, mode_err}, 32'h1);

    // R8 override: privileged modes see user copies
    user_bank = 1'b1;
    for (int mi = 1; mi < 6; mi++) begin
      set_mode(modes[mi]);
      for (int i = 8; i < 15; i++) begin
        read_pair(i, i, a, b);
        chk("R8", a, model[0][i]);
      end
    end
    set_mode(5'b10001);
    do_write(9, 32'hCAFE_0009);
    model[0][9] = 32'hCAFE_0009;
    do_write(13, 32'hCAFE_000D);
    model[0][13] = 32'hCAFE_000D;
    user_bank = 1'b0;
    read_pair(9, 13, a, b);
    chk("R8", a, model[1][9]);
    chk("R8", b, model[1][13]);
    set_mode(5'b10000);
    read_pair(9, 13, a, b);
    chk("R8", a, 32'hCAFE_0009);
    chk("R8", b, 32'hCAFE_000D);

    // R7 read-before-write on both ports
    @(negedge clk);
    ra_idx = 4'd3; rb_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hBEEF_0003;
    #1;
    chk("R7", ra_data, model[0][3]);
    chk("R7", rb_data, model[0][3]);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7", ra_data, 32'hBEEF_0003);
    chk("R7", rb_data, 32'hBEEF_0003);

    // R5 saved status per exception mode; R8 override does not move it
    user_bank = 1'b1;
    for (int mi = 1; mi < 6; mi++) begin
      set_mode(modes[mi]);
      @(negedge clk);
      spsr_we = 1'b1; spsr_wdata = 32'h5000_0000 + 32'(mi);
      @(negedge clk);
      spsr_we = 1'b0;
    end
    user_bank = 1'b0;
    for (int mi = 1; mi < 6; mi++) begin
      set_mode(modes[mi]);
      @(negedge clk);
      spsr_re = 1'b1;
      #1;
      chk("R5", spsr_rdata, 32'h5000_0000 + 32'(mi));
      chk("R6", {31'h0, spsr_invalid}, 32'h0);
      spsr_re = 1'b0;
    end

    // R6 saved status in User, System and unknown modes
    for (int mi = 0; mi < 8; mi++) begin
      if (mi != 0 && mi != 6 && mi != 7) continue;
      set_mode(modes[mi]);
      @(negedge clk);
      spsr_we = 1'b1; spsr_wdata = 32'hFFFF_FFFF;
      #1;
      chk("R6", {31'h0, spsr_invalid}, 32'h1);
      chk("R6", spsr_rdata, 32'h0);
      @(negedge clk);
      spsr_we = 1'b0;
      #1 chk("R6", {31'h0, spsr_invalid}, 32'h0);
    end
    for (int mi = 1; mi < 6; mi++) begin
      set_mode(modes[mi]);
      #1 chk("R6", spsr_rdata, 32'h5000_0000 + 32'(mi));
    end
    #1 chk("R9", {31'h0, mode_err}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule